// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

This block is a sequential lock that checks an entered sequence of three values against a secret combination. The three secret values are fixed parameters. A user presents one value at a time on `entry_value` and pulses `entry_valid` for one clock cycle to submit it. A small control machine steps through the three digit positions. A datapath multiplexer, steered by that machine, picks the secret value for the current position. An equality comparator tests the submitted value against the picked one.

The control state is held in four flip-flops with a one-hot style encoding. The low three bits act directly as the one-hot multiplexer select, and the top bit is the unlock indication. Both outputs are therefore registered, and no decode logic sits between the state and the pins. A correct sequence ends in an open state. Any wrong value ends in an error state that keeps the lock closed. Both end states persist until a synchronous reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes the first-digit state on that edge, whatever the state was before. After that edge, `code_sel` = 3'b001 and `unlocked` = 0.
- R2: `code_sel` is the low three state bits and `unlocked` is the top state bit. The state codes are: first digit 4'b0001, second 4'b0010, third 4'b0100, open 4'b1000 and error 4'b0000. Select 3'b001 picks `CODE0`, 3'b010 picks `CODE1` and 3'b100 picks `CODE2`.
- R3: In the three digit states, a clock edge with `entry_valid` low leaves the state unchanged, whatever `entry_value` is.
- R4: In a digit state, an edge with `entry_valid` high and `entry_value` equal to the selected secret value advances the machine. First goes to second, second goes to third, and third goes to open (`unlocked` = 1, `code_sel` = 3'b000).
- R5: In a digit state, an edge with `entry_valid` high and `entry_value` different from the selected secret value in any bit moves the machine to error. In error, `code_sel` = 3'b000 and `unlocked` = 0.
- R6: The open state holds until reset, whatever is submitted.
- R7: The error state holds until reset, even when correct values are submitted afterwards.
- R8: The match is exact equality over all `W` bits. For a digit position, exactly one of the 2^W possible values advances the machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to the first-digit state |
| entry_valid | input | 1 | One-cycle strobe that submits `entry_value` |
| entry_value | input | W | Value being entered |
| unlocked | output | 1 | 1 = open, 0 = closed (top state bit) |
| code_sel | output | 3 | One-hot select of the secret value being compared (low state bits) |

## Verification
The assertions check on every cycle that:
- the state never has more than one bit set;
- a cycle without a strobe leaves the state alone;
- a strobed mismatch lands in error;
- the two end states are sticky;
- reset returns the machine to the first-digit state.

Only the bench scenarios can show that the right secret value is tied to each select code and that exactly one value per position advances the machine. To do this, the bench sweeps every possible value at each of the three positions after a correct prefix. It also drives correct values after an error and arbitrary values after an open.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef logic [3:0] lock_state_t;
  localparam lock_state_t ST_DIG0 = 4'b0001;
  localparam lock_state_t ST_DIG1 = 4'b0010;
  localparam lock_state_t ST_DIG2 = 4'b0100;
  localparam lock_state_t ST_OPEN = 4'b1000;
  localparam lock_state_t ST_ERR  = 4'b0000;
  localparam int unsigned NUM_DIGITS = 3;
endpackage

// File: rtl/lock_cmp.sv
module lock_cmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  always_comb eq = (a == b);
endmodule

// File: rtl/lock_code_mux.sv
module lock_code_mux #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 3
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] codes,
  output logic [W-1:0]        picked
);
  logic [N-1:0][W-1:0] masked;

  // AND-OR selection driven by a one-hot select
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = codes[i] & {W{sel[i]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) picked = picked | masked[i];
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        entry_valid,
  input  logic        match,
  output lock_state_t state_q
);
  lock_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DIG0, ST_DIG1, ST_DIG2:
        if (entry_valid) state_d = match ? lock_state_t'(state_q << 1) : ST_ERR;
      ST_OPEN: state_d = ST_OPEN;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_DIG0;
    else     state_q <= state_d;
  end

  logic in_digit;
  assign in_digit = (state_q == ST_DIG0) || (state_q == ST_DIG1) || (state_q == ST_DIG2);

  a_r1_reset_first: assert property (@(posedge clk) rst |=> state_q == ST_DIG0);
  a_r2_state_legal: assert property (@(posedge clk) disable iff (rst) $onehot0(state_q));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (in_digit && !entry_valid) |=> $stable(state_q));
  a_r5_miss_err: assert property (@(posedge clk) disable iff (rst)
    (in_digit && entry_valid && !match) |=> state_q == ST_ERR);
  a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN) |=> state_q == ST_OPEN);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR) |=> state_q == ST_ERR);
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] CODE0 = 4'h3,
  parameter logic [W-1:0] CODE1 = 4'hA,
  parameter logic [W-1:0] CODE2 = 4'h6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         entry_valid,
  input  logic [W-1:0] entry_value,
  output logic         unlocked,
  output logic [2:0]   code_sel
);
  localparam int unsigned N = NUM_DIGITS;

  lock_state_t          state_q;
  logic [N-1:0][W-1:0]  codes;
  logic [W-1:0]         picked;
  logic                 match;

  assign codes[0] = CODE0;
  assign codes[1] = CODE1;
  assign codes[2] = CODE2;

  lock_code_mux #(.W(W), .N(N)) mux_i (
    .sel(state_q[N-1:0]), .codes(codes), .picked(picked));

  lock_cmp #(.W(W)) cmp_i (.a(entry_value), .b(picked), .eq(match));

  lock_fsm fsm_i (
    .clk(clk), .rst(rst), .entry_valid(entry_valid),
    .match(match), .state_q(state_q));

  // Outputs are plain state bits: no decode
  assign code_sel = state_q[2:0];
  assign unlocked = state_q[3];

  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && match && code_sel != 3'b000) |=>
      ({unlocked, code_sel} == $past({unlocked, code_sel}) << 1));
endmodule

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;
  localparam int unsigned W = 4;
  localparam logic [W-1:0] K0 = 4'h3;
  localparam logic [W-1:0] K1 = 4'hA;
  localparam logic [W-1:0] K2 = 4'h6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_valid = 1'b0;
  logic [W-1:0] entry_value = '0;
  logic unlocked;
  logic [2:0] code_sel;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] key [3];

  always #4 clk = ~clk;

  combo_lock #(.W(W), .CODE0(K0), .CODE1(K1), .CODE2(K2)) dut_i (
    .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_value(entry_value),
    .unlocked(unlocked), .code_sel(code_sel));

  task automatic check(input string req, input logic [2:0] sel_e, input logic open_e);
    checks++;
    if (code_sel !== sel_e || unlocked !== open_e) begin
      errors++;
      $display("FAIL %s: sel=%b open=%b expected sel=%b open=%b",
               req, code_sel, unlocked, sel_e, open_e);
    end
  endtask

  // drive at negedge, take one rising edge, return at the next negedge
  task automatic step(input logic v, input logic [W-1:0] val);
    entry_valid = v;
    entry_value = val;
    @(posedge clk);
    @(negedge clk);
    entry_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, '0);
    rst = 1'b0;
  endtask

  initial begin
    key[0] = K0; key[1] = K1; key[2] = K2;
    @(negedge clk);
    do_reset();
    check("R1 reset state", 3'b001, 1'b0);

    // R4: correct sequence opens
    step(1'b1, K0); check("R4 first->second", 3'b010, 1'b0);
    step(1'b1, K1); check("R4 second->third", 3'b100, 1'b0);
    step(1'b1, K2); check("R4 third->open", 3'b000, 1'b1);
    // R6: open ignores further entries
    for (int v = 0; v < 16; v++) begin
      step(1'b1, v[W-1:0]); check("R6 open sticky", 3'b000, 1'b1);
    end
    // R1: reset from open
    do_reset(); check("R1 reset from open", 3'b001, 1'b0);

    // R8/R4/R5/R3/R2: sweep every value at every position
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        for (int q = 0; q < p; q++) step(1'b1, key[q]);
        // R3: no strobe, value on the bus is the right one
        step(1'b0, key[p]); check("R3 idle hold", 3'(1 << p), 1'b0);
        step(1'b0, ~key[p]); check("R3 idle hold", 3'(1 << p), 1'b0);
        step(1'b1, v[W-1:0]);
        if (v[W-1:0] == key[p]) begin
          if (p == 2) check("R8 R4 match at third", 3'b000, 1'b1);
          else        check("R8 R4 match advances", 3'(1 << (p + 1)), 1'b0);
        end else begin
          check("R8 R5 mismatch to error", 3'b000, 1'b0);
          // R7: correct values afterwards do not escape error
          for (int q = 0; q < 3; q++) begin
            step(1'b1, key[q]); check("R7 error sticky", 3'b000, 1'b0);
          end
          step(1'b0, '0); check("R7 error idle", 3'b000, 1'b0);
        end
      end
    end

    // R2: secret values are position specific (swapped order fails)
    do_reset();
    step(1'b1, K1); check("R2 select picks CODE0", 3'b000, 1'b0);
    // R1: reset from error, with strobe asserted during reset
    rst = 1'b1; step(1'b1, K0); rst = 1'b0;
    check("R1 reset overrides strobe", 3'b001, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule